// File: doc/BRIEF.md
# Smart-Card Receive Character Buffer with Parity Policy

This block sits behind a smart-card character receiver. Each received character arrives with a flag that says whether its parity was correct. Good characters are held in a small first-in first-out buffer until the host reads them. The usable depth of the buffer is set by a 3-bit field and runs from one to eight entries. The block reports empty and full states, and keeps a sticky parity-error flag with an active-low interrupt request.

Bad characters are handled according to the protocol select. In character-oriented mode (T=0), a bad character is thrown away and counted. The flag is raised only after a programmable number of consecutive bad characters. After the flag fires, the counter stays idle until the host rewrites the threshold field. In block-oriented mode (T=1), a bad character is stored like any other, and the flag is raised at once.

Top module: `sc_rx_fifo`

## Requirements
- R1: The usable depth is depth_sel_i + 1 (3'b000 gives 1, 3'b111 gives 8). full_o is high exactly when that many characters are held.
- R2: empty_o is high while no character is held and drops in the cycle after one is stored. full_o drops in the cycle after a read from a full buffer.
- R3: A character that arrives while the buffer is full is discarded. This also holds when a read is strobed in the same cycle, and the count never exceeds the depth.
- R4: A read strobe on rd_i puts the oldest character on rd_data_o in the next cycle, in arrival order. A read of an empty buffer leaves rd_data_o and the contents unchanged.
- R5: Any change of depth_sel_i empties the buffer in the next cycle and discards that cycle's write and read.
- R6: With proto_t1_i = 0, a character with rx_par_ok_i = 0 is not stored.
- R7: With proto_t1_i = 0, pe_o rises after pec_sel_i + 1 consecutive bad characters (3'b000 gives 1, 3'b111 gives 8). A good character in between restarts the count.
- R8: With proto_t1_i = 0, once pe_o has fired, further bad characters are not counted until a pec_wr_i pulse rearms the counter and clears it.
- R9: With proto_t1_i = 1, a bad character is stored, and pe_o rises on the first one, whatever the counter holds.
- R10: pe_o stays high until a stat_rd_i pulse. If a new error and stat_rd_i occur in the same cycle, the error wins. irq_no is low exactly while pe_o is high.
- R11: After reset, empty_o = 1, full_o = 0, pe_o = 0, irq_no = 1, rd_data_o = 0, and the error counter is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | One-cycle strobe: a character has been received |
| rx_data_i | input | 8 | Received character |
| rx_par_ok_i | input | 1 | 1 = parity of the character is correct |
| proto_t1_i | input | 1 | 0 = T=0 policy, 1 = T=1 policy |
| depth_sel_i | input | 3 | Depth field, depth = value + 1 |
| pec_sel_i | input | 3 | Error threshold field, errors = value + 1 |
| pec_wr_i | input | 1 | Pulse: threshold field rewritten, rearms the counter |
| rd_i | input | 1 | Host read strobe for the data register |
| stat_rd_i | input | 1 | Host read strobe for the status register, clears pe_o |
| rd_data_o | output | 8 | Last character read by the host |
| empty_o | output | 1 | No character held |
| full_o | output | 1 | Held count equals the programmed depth |
| pe_o | output | 1 | Sticky parity-error flag |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
The assertions assume that rx_valid_i, rd_i, pec_wr_i and stat_rd_i are single-cycle strobes sampled on the rising edge. They also assume that depth_sel_i and proto_t1_i change only between characters. The stimulus drives every input on the falling edge and returns each strobe low after one cycle. The depth field is changed only when no character is in flight, and the bench waits one cycle after each change before it sends data, so the flush never collides with a transfer it expects to land.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned SEL_W  = 3;

  typedef enum logic {
    PROTO_T0 = 1'b0,
    PROTO_T1 = 1'b1
  } proto_e;
endpackage

// File: rtl/sc_rx_store.sv
module sc_rx_store #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SEL_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_i,
  input  logic [SEL_W-1:0]  depth_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              flush_o
);
  localparam int unsigned DEPTH_MAX = 1 << SEL_W;
  localparam int unsigned CNT_W     = SEL_W + 1;

  logic [DATA_W-1:0] mem_q [DEPTH_MAX];
  logic [SEL_W-1:0]  wr_ptr_q, rd_ptr_q, depth_q;
  logic [CNT_W-1:0]  cnt_q, depth_len;
  logic              wr_en, rd_en;

  assign depth_len = {1'b0, depth_q} + CNT_W'(1);
  assign flush_o   = depth_sel_i != depth_q;
  assign empty_o   = cnt_q == '0;
  assign full_o    = cnt_q == depth_len;
  assign wr_en     = wr_i & ~full_o & ~flush_o;
  assign rd_en     = rd_i & ~empty_o & ~flush_o;

  function automatic logic [SEL_W-1:0] ptr_inc(input logic [SEL_W-1:0] p,
                                               input logic [SEL_W-1:0] last);
    return (p == last) ? '0 : p + SEL_W'(1);
  endfunction

  for (genvar i = 0; i < DEPTH_MAX; i++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                mem_q[i] <= '0;
      else if (wr_en && wr_ptr_q == SEL_W'(i))    mem_q[i] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q  <= '0;
      rd_ptr_q  <= '0;
      cnt_q     <= '0;
      depth_q   <= '0;
      rd_data_o <= '0;
    end else if (flush_o) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      depth_q  <= depth_sel_i;
    end else begin
      if (wr_en) wr_ptr_q <= ptr_inc(wr_ptr_q, depth_q);
      if (rd_en) begin
        rd_ptr_q  <= ptr_inc(rd_ptr_q, depth_q);
        rd_data_o <= mem_q[rd_ptr_q];
      end
      case ({wr_en, rd_en})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= depth_len);
  p_full_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && wr_i && !rd_i && !flush_o) |=> cnt_q == $past(cnt_q));
  p_empty_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && rd_i) |=> $stable(rd_data_o));
  p_flush_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> empty_o);
endmodule

// File: rtl/sc_rx_parity.sv
module sc_rx_parity #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_valid_i,
  input  logic             rx_par_ok_i,
  input  logic             proto_t1_i,
  input  logic [SEL_W-1:0] pec_sel_i,
  input  logic             pec_wr_i,
  input  logic             stat_rd_i,
  output logic             store_o,
  output logic             pe_o
);
  import sc_rx_pkg::*;

  logic [SEL_W-1:0] err_cnt_q;
  logic             armed_q, pe_q, bad, t0_bad, t0_trip, set_pe;
  proto_e           proto;

  assign proto   = proto_e'(proto_t1_i);
  assign bad     = rx_valid_i & ~rx_par_ok_i;
  assign t0_bad  = bad & (proto == PROTO_T0);
  assign t0_trip = t0_bad & armed_q & (err_cnt_q == pec_sel_i);
  assign set_pe  = t0_trip | (bad & (proto == PROTO_T1));
  assign store_o = rx_valid_i & (rx_par_ok_i | (proto == PROTO_T1));
  assign pe_o    = pe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_cnt_q <= '0;
      armed_q   <= 1'b1;
    end else if (pec_wr_i) begin
      err_cnt_q <= '0;
      armed_q   <= 1'b1;
    end else if (proto == PROTO_T0 && rx_valid_i && armed_q) begin
      if (rx_par_ok_i) begin
        err_cnt_q <= '0;
      end else if (t0_trip) begin
        err_cnt_q <= '0;
        armed_q   <= 1'b0;
      end else begin
        err_cnt_q <= err_cnt_q + SEL_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pe_q <= 1'b0;
    else if (set_pe)    pe_q <= 1'b1;
    else if (stat_rd_i) pe_q <= 1'b0;
  end

  p_t1_first_error_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !rx_par_ok_i && proto_t1_i) |=> pe_o);
  p_pe_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pe_q && !stat_rd_i) |=> pe_q);
  p_disarmed_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q && !pec_wr_i && !proto_t1_i && !pe_q) |=> !pe_q);
  p_good_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_par_ok_i && !proto_t1_i && !pec_wr_i) |=> err_cnt_q == '0);
endmodule

// File: rtl/sc_rx_fifo.sv
module sc_rx_fifo (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_data_i,
  input  logic       rx_par_ok_i,
  input  logic       proto_t1_i,
  input  logic [2:0] depth_sel_i,
  input  logic [2:0] pec_sel_i,
  input  logic       pec_wr_i,
  input  logic       rd_i,
  input  logic       stat_rd_i,
  output logic [7:0] rd_data_o,
  output logic       empty_o,
  output logic       full_o,
  output logic       pe_o,
  output logic       irq_no
);
  import sc_rx_pkg::*;

  logic store, flush;

  sc_rx_parity #(.SEL_W(SEL_W)) u_parity (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_valid_i  (rx_valid_i),
    .rx_par_ok_i (rx_par_ok_i),
    .proto_t1_i  (proto_t1_i),
    .pec_sel_i   (pec_sel_i),
    .pec_wr_i    (pec_wr_i),
    .stat_rd_i   (stat_rd_i),
    .store_o     (store),
    .pe_o        (pe_o)
  );

  sc_rx_store #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (store),
    .wr_data_i   (rx_data_i),
    .rd_i        (rd_i),
    .depth_sel_i (depth_sel_i),
    .rd_data_o   (rd_data_o),
    .empty_o     (empty_o),
    .full_o      (full_o),
    .flush_o     (flush)
  );

  assign irq_no = ~pe_o;

  p_t0_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !rx_par_ok_i && !proto_t1_i && empty_o && !rd_i && !flush)
      |=> empty_o);
  p_irq_level_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pe_o) |-> !irq_no);
endmodule

// File: tb/sc_rx_fifo_tb.sv
module sc_rx_fifo_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       par_ok = 1'b1;
  logic       t1 = 1'b0;
  logic [2:0] depth_sel = '0;
  logic [2:0] pec_sel = '0;
  logic       pec_wr = 1'b0;
  logic       rd = 1'b0;
  logic       stat_rd = 1'b0;
  logic [7:0] rd_data;
  logic       empty, full, pe, irq_n;
  int         n_checks = 0;
  int         n_errors = 0;

  always #5 clk = ~clk;

  sc_rx_fifo u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_par_ok_i(par_ok), .proto_t1_i(t1), .depth_sel_i(depth_sel),
    .pec_sel_i(pec_sel), .pec_wr_i(pec_wr), .rd_i(rd), .stat_rd_i(stat_rd),
    .rd_data_o(rd_data), .empty_o(empty), .full_o(full), .pe_o(pe), .irq_no(irq_n)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic ok);
    rx_valid = 1'b1; rx_data = d; par_ok = ok;
    @(negedge clk);
    rx_valid = 1'b0; par_ok = 1'b1;
  endtask

  task automatic read_one();
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic pulse_stat();
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic pulse_pec(input logic [2:0] v);
    pec_sel = v; pec_wr = 1'b1; @(negedge clk); pec_wr = 1'b0;
  endtask

  task automatic set_depth(input logic [2:0] v);
    depth_sel = v; @(negedge clk);
  endtask

  task automatic t_reset();
    check("R11", "empty", empty, 1);
    check("R11", "full", full, 0);
    check("R11", "pe", pe, 0);
    check("R11", "irq_n", irq_n, 1);
    check("R11", "rd_data", rd_data, 0);
  endtask

  task automatic t_depth(input logic [2:0] sel);
    int len = int'(sel) + 1;
    set_depth(sel);
    for (int i = 0; i < len; i++) begin
      check("R1", "full before depth reached", full, 0);
      send(8'h10 + 8'(i), 1'b1);
      check("R2", "empty after store", empty, 0);
    end
    check("R1", "full at depth", full, 1);
    send(8'hEE, 1'b1);
    check("R3", "full after extra write", full, 1);
    for (int i = 0; i < len; i++) begin
      read_one();
      check("R4", "order", rd_data, 8'h10 + i);
      if (i == 0) check("R2", "full clears after read", full, 0);
    end
    check("R3", "extra write discarded, empty", empty, 1);
  endtask

  task automatic t_full_rw();
    set_depth(3'd1);
    send(8'hA0, 1'b1);
    send(8'hA1, 1'b1);
    check("R1", "full at depth 2", full, 1);
    rx_valid = 1'b1; rx_data = 8'hA2; rd = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; rd = 1'b0;
    check("R4", "read during full write", rd_data, 8'hA0);
    check("R3", "not full after read", full, 0);
    read_one();
    check("R3", "second entry", rd_data, 8'hA1);
    check("R3", "write on full discarded", empty, 1);
  endtask

  task automatic t_empty_read();
    read_one();
    check("R4", "empty read holds data", rd_data, 8'hA1);
    check("R4", "empty read keeps empty", empty, 1);
  endtask

  task automatic t_flush();
    set_depth(3'd7);
    send(8'h31, 1'b1); send(8'h32, 1'b1); send(8'h33, 1'b1);
    set_depth(3'd5);
    check("R5", "flushed", empty, 1);
    send(8'h44, 1'b1);
    read_one();
    check("R5", "first after flush", rd_data, 8'h44);
    check("R5", "empty again", empty, 1);
  endtask

  task automatic t_t0();
    set_depth(3'd7);
    t1 = 1'b0;
    pulse_pec(3'd2);
    send(8'h51, 1'b0);
    check("R6", "bad char dropped", empty, 1);
    send(8'h52, 1'b0);
    send(8'h53, 1'b1);
    send(8'h54, 1'b0);
    send(8'h55, 1'b0);
    check("R7", "good char restarted count", pe, 0);
    send(8'h56, 1'b0);
    check("R7", "pe at threshold", pe, 1);
    check("R10", "irq low", irq_n, 0);
    repeat (3) @(negedge clk);
    check("R10", "pe holds", pe, 1);
    pulse_stat();
    check("R10", "pe cleared by status read", pe, 0);
    check("R10", "irq released", irq_n, 1);
    read_one();
    check("R6", "only good char stored", rd_data, 8'h53);
    check("R6", "empty after good char", empty, 1);
    for (int i = 0; i < 4; i++) send(8'h60, 1'b0);
    check("R8", "disarmed counter", pe, 0);
    pulse_pec(3'd0);
    send(8'h61, 1'b0);
    check("R8", "rearmed, pe after 1 error", pe, 1);
    send(8'h62, 1'b0);
    stat_rd = 1'b1; send(8'h63, 1'b0); stat_rd = 1'b0;
    check("R10", "clear then disarmed", pe, 0);
    pulse_pec(3'd7);
    for (int i = 0; i < 7; i++) send(8'h70, 1'b0);
    check("R7", "threshold 8 not yet", pe, 0);
    send(8'h71, 1'b0);
    check("R7", "threshold 8 reached", pe, 1);
    pulse_stat();
  endtask

  task automatic t_t1();
    t1 = 1'b1;
    pulse_pec(3'd7);
    send(8'h5A, 1'b0);
    check("R9", "pe on first bad", pe, 1);
    check("R9", "bad stored", empty, 0);
    stat_rd = 1'b1; send(8'h5B, 1'b0); stat_rd = 1'b0;
    check("R10", "set wins over clear", pe, 1);
    read_one();
    check("R9", "bad char data", rd_data, 8'h5A);
    read_one();
    check("R9", "second bad char", rd_data, 8'h5B);
    pulse_stat();
    check("R10", "cleared", pe, 0);
    t1 = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_depth(3'd0);
    t_depth(3'd3);
    t_depth(3'd7);
    t_full_rw();
    t_empty_read();
    t_flush();
    t_t0();
    t_t1();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule